// File: doc/BRIEF.md
# Processor packet insert buffer

A staging buffer through which a host processor injects one packet fragment into an egress datapath. The host writes byte-wide words through a plain address/write-enable port. The words are a flags word, a payload-length word and a logical-identifier word, followed by the payload bytes. The host then writes a commit address to mark the fragment as available. The buffer holds a single fragment at a time.

The egress side drains the fragment over a valid/ready handshake, one payload byte per accepted transfer and in write order. Beside each byte it presents start and end markers, a last-byte indication, the logical identifier and the three error flags. The identifier also selects which of four downstream ports receives the fragment; that decode lies outside this block. Once the last valid byte is accepted, the buffer frees itself and the host may load the next fragment. While a fragment is pending, every host write is dropped and a busy output is high.

Top module: `pkt_insert_buffer`

## Requirements
- R1: After synchronous reset, `eg_valid` and `host_busy` are 0, and all stored flag bits are cleared: a fragment committed after reset without a new flags write shows `eg_sop`, `eg_eop` and `eg_err` as 0.
- R2: Host address map: 0 is flags, 1 is length, 2 is logical identifier, and 3+i is payload byte i for i from 0 to 255. A write to address 259 while not busy raises `eg_valid` and `host_busy` from the next cycle.
- R3: Payload bytes appear on `eg_data` in increasing index order. The buffer advances one byte per cycle in which `eg_valid` and `eg_ready` are both high, and holds the current byte while `eg_ready` is low.
- R4: The length word gives the count of valid payload bytes, with 1 to 255 meaning themselves and 0 meaning 256. `eg_last` is high exactly on the byte at that count.
- R5: `eg_sop` is high only on the first payload byte, and only if flags bit 0 was written as 1.
- R6: `eg_eop` is high only on the last payload byte, and only if flags bit 1 was 1. `eg_err[0]`, `eg_err[1]` and `eg_err[2]` carry flags bits 2 (address parity), 3 (data parity) and 4 (packet error) on the last byte, and are 0 on every other byte. Flags bits 7 to 5 are ignored.
- R7: `eg_lid` shows the stored logical identifier while `eg_valid` is high.
- R8: While `host_busy` is high, host writes to any address, including the commit address, have no effect on the pending fragment.
- R9: In the cycle after the last byte is accepted, `eg_valid` and `host_busy` are 0, and a new fragment may be loaded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 9 | Host word address |
| host_wdata | input | 8 | Host write data |
| host_busy | output | 1 | Fragment pending; host writes dropped |
| eg_valid | output | 1 | Egress byte valid |
| eg_ready | input | 1 | Egress consumer ready |
| eg_data | output | 8 | Egress payload byte |
| eg_sop | output | 1 | Start of packet on this byte |
| eg_eop | output | 1 | End of packet on this byte |
| eg_last | output | 1 | Last valid byte of the fragment |
| eg_err | output | 3 | Packet, data-parity and address-parity error flags (bit 2 to 0) |
| eg_lid | output | 8 | Logical identifier |

## Verification
Directed fragments of lengths 1, 256 (length code 0) and 255 exercise the boundary cases. A one-byte fragment must show start and end markers on the same byte. The 256-byte case tells the zero encoding apart from an empty fragment, and 255 separates the count from an off-by-one. Random fragments with random lengths, flags, identifiers and payloads are drained under random ready stalls, which separates correct advance-on-handshake from free-running reads. Writes issued while busy, and a commit after reset with no fresh flags write, show that the pending contents and the cleared flags are both preserved.

// File: rtl/pkt_insert_buffer.sv
module pkt_insert_buffer #(
  parameter int DW    = 8,
  parameter int DEPTH = 256,
  parameter int HDR   = 3,
  parameter int AW    = $clog2(DEPTH + HDR + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_we,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic          host_busy,
  output logic          eg_valid,
  input  logic          eg_ready,
  output logic [DW-1:0] eg_data,
  output logic          eg_sop,
  output logic          eg_eop,
  output logic          eg_last,
  output logic [2:0]    eg_err,
  output logic [DW-1:0] eg_lid
);
  localparam int CW     = $clog2(DEPTH);
  localparam int COMMIT = HDR + DEPTH;

  logic [DW-1:0] mem [DEPTH];
  logic [4:0]    flg;
  logic [DW-1:0] len_q;
  logic [DW-1:0] lid_q;
  logic          avail;
  logic [CW-1:0] rd_idx;

  logic          accept;
  logic          in_data;
  logic [CW-1:0] wr_idx;
  logic [CW-1:0] last_idx;
  logic          at_last;
  logic          xfer;

  assign accept   = host_we && !avail;
  assign in_data  = (host_addr >= AW'(HDR)) && (host_addr < AW'(COMMIT));
  assign wr_idx   = CW'(host_addr - AW'(HDR));
  assign last_idx = CW'(len_q - DW'(1));
  assign at_last  = rd_idx == last_idx;
  assign xfer     = avail && eg_ready;

  always_ff @(posedge clk) begin
    if (accept && in_data) mem[wr_idx] <= host_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flg    <= '0;
      len_q  <= '0;
      lid_q  <= '0;
      avail  <= 1'b0;
      rd_idx <= '0;
    end else if (accept) begin
      case (host_addr)
        AW'(0):      flg   <= host_wdata[4:0];
        AW'(1):      len_q <= host_wdata;
        AW'(2):      lid_q <= host_wdata;
        AW'(COMMIT): begin
          avail  <= 1'b1;
          rd_idx <= '0;
        end
        default: ;
      endcase
    end else if (xfer) begin
      if (at_last) begin
        avail  <= 1'b0;
        rd_idx <= '0;
      end else begin
        rd_idx <= rd_idx + CW'(1);
      end
    end
  end

  assign host_busy = avail;
  assign eg_valid  = avail;
  assign eg_data   = mem[rd_idx];
  assign eg_last   = avail && at_last;
  assign eg_sop    = avail && (rd_idx == '0) && flg[0];
  assign eg_eop    = eg_last && flg[1];
  assign eg_err    = eg_last ? flg[4:2] : 3'b000;
  assign eg_lid    = lid_q;
endmodule

// File: rtl/pkt_insert_buffer_chk.sv
module pkt_insert_buffer_chk #(
  parameter int DW    = 8,
  parameter int DEPTH = 256,
  parameter int HDR   = 3,
  parameter int AW    = 9
) (
  input logic          clk,
  input logic          rst,
  input logic          host_we,
  input logic [AW-1:0] host_addr,
  input logic          host_busy,
  input logic          eg_valid,
  input logic          eg_ready,
  input logic [DW-1:0] eg_data,
  input logic          eg_sop,
  input logic          eg_eop,
  input logic          eg_last,
  input logic [2:0]    eg_err,
  input logic [DW-1:0] eg_lid
);
  a_r2_commit_raises_valid: assert property (@(posedge clk) disable iff (rst)
    host_we && host_addr == AW'(HDR + DEPTH) && !host_busy |=> eg_valid);

  a_r3_stall_holds_byte: assert property (@(posedge clk) disable iff (rst)
    eg_valid && !eg_ready |=> eg_valid && $stable(eg_data) && $stable(eg_last));

  a_r5_sop_not_after_first: assert property (@(posedge clk) disable iff (rst)
    eg_valid && eg_ready && !eg_last |=> !eg_sop);

  a_r6_err_only_on_last: assert property (@(posedge clk) disable iff (rst)
    !eg_last |-> eg_err == 3'b000 && !eg_eop);

  a_r8_busy_holds_lid: assert property (@(posedge clk) disable iff (rst)
    eg_valid && !(eg_ready && eg_last) |=> eg_valid && $stable(eg_lid));

  a_r9_clear_after_last: assert property (@(posedge clk) disable iff (rst)
    eg_valid && eg_ready && eg_last |=> !eg_valid && !host_busy);
endmodule

bind pkt_insert_buffer pkt_insert_buffer_chk #(
  .DW(DW), .DEPTH(DEPTH), .HDR(HDR), .AW(AW)
) u_chk (
  .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
  .host_busy(host_busy), .eg_valid(eg_valid), .eg_ready(eg_ready),
  .eg_data(eg_data), .eg_sop(eg_sop), .eg_eop(eg_eop), .eg_last(eg_last),
  .eg_err(eg_err), .eg_lid(eg_lid)
);

// File: tb/pkt_insert_buffer_bench.sv
module pkt_insert_buffer_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       host_we = 1'b0;
  logic [8:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic       host_busy, eg_valid, eg_sop, eg_eop, eg_last;
  logic       eg_ready = 1'b0;
  logic [7:0] eg_data, eg_lid;
  logic [2:0] eg_err;

  int total = 0;
  int bad = 0;
  bit timeout = 0;
  logic [7:0] pay [256];

  always #4 clk = ~clk;

  pkt_insert_buffer u_pkt_insert_buffer (
    .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_busy(host_busy), .eg_valid(eg_valid),
    .eg_ready(eg_ready), .eg_data(eg_data), .eg_sop(eg_sop), .eg_eop(eg_eop),
    .eg_last(eg_last), .eg_err(eg_err), .eg_lid(eg_lid)
  );

  function automatic int byte_count(logic [7:0] code);
    return (code == 8'd0) ? 256 : int'(code);
  endfunction

  function automatic logic [21:0] exp_word(int k, int n, logic [7:0] fl,
                                           logic [7:0] lid, logic [7:0] b);
    logic lst = (k == n - 1);
    return {b, (k == 0) && fl[0], lst && fl[1], lst,
            lst ? fl[4:2] : 3'b000, lid};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic hwrite(int a, logic [7:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = 9'(a); host_wdata = d;
    @(posedge clk); #1;
    host_we = 1'b0;
  endtask

  task automatic load(logic [7:0] fl, logic [7:0] code, logic [7:0] lid);
    int n = byte_count(code);
    hwrite(0, fl); hwrite(1, code); hwrite(2, lid);
    for (int i = 0; i < n; i++) hwrite(3 + i, pay[i]);
    hwrite(259, 8'h00);
    @(negedge clk); #1;
    check("R2 valid/busy after commit", {30'd0, eg_valid, host_busy}, 32'd3);
  endtask

  task automatic drain(logic [7:0] fl, logic [7:0] code, logic [7:0] lid, bit stalls);
    int n = byte_count(code);
    int k = 0;
    int beats = 0;
    while (k < n && beats < 4000) begin
      @(negedge clk);
      eg_ready = stalls ? ($urandom % 4 != 0) : 1'b1;
      #1;
      check($sformatf("R3 R4 R5 R6 R7 byte %0d", k),
            {9'd0, eg_valid, eg_data, eg_sop, eg_eop, eg_last, eg_err, eg_lid},
            {9'd0, 1'b1, exp_word(k, n, fl, lid, pay[k])});
      if (eg_ready) k++;
      beats++;
    end
    @(negedge clk);
    eg_ready = 1'b0;
    #1;
    check("R9 freed after last", {30'd0, eg_valid, host_busy}, 32'd0);
  endtask

  task automatic run_all();
    logic [7:0] fl, code, lid;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset outputs", {30'd0, eg_valid, host_busy}, 32'd0);
    @(negedge clk); rst = 1'b0;

    for (int i = 0; i < 256; i++) pay[i] = 8'(i * 7 + 3);
    load(8'hFF, 8'd1, 8'h5A); drain(8'hFF, 8'd1, 8'h5A, 0);
    load(8'h03, 8'd0, 8'hC1); drain(8'h03, 8'd0, 8'hC1, 1);
    load(8'h1C, 8'd255, 8'h02); drain(8'h1C, 8'd255, 8'h02, 1);

    for (int i = 0; i < 8; i++) pay[i] = 8'($urandom);
    load(8'h1F, 8'd8, 8'h77);
    hwrite(3, ~pay[0]); hwrite(0, 8'h00); hwrite(1, 8'd2);
    hwrite(2, 8'h11); hwrite(259, 8'h00);
    drain(8'h1F, 8'd8, 8'h77, 1);

    for (int i = 0; i < 4; i++) pay[i] = 8'($urandom);
    load(8'h1F, 8'd4, 8'h33);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    #1;
    check("R1 valid cleared by reset", {31'd0, eg_valid}, 32'd0);
    hwrite(1, 8'd4); hwrite(2, 8'h44);
    for (int i = 0; i < 4; i++) hwrite(3 + i, pay[i]);
    hwrite(259, 8'h00);
    drain(8'h00, 8'd4, 8'h44, 0);

    for (int t = 0; t < 20; t++) begin
      fl = 8'($urandom); code = 8'($urandom % 40); lid = 8'($urandom);
      if (t == 5) code = 8'd2;
      for (int i = 0; i < byte_count(code); i++) pay[i] = 8'($urandom);
      load(fl, code, lid);
      drain(fl, code, lid, 1);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        timeout = 1;
      end
    join_any
    disable fork;
    if (timeout) begin
      total++; bad++;
      $display("FAIL watchdog actual=expired expected=finished");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule